// File: doc/BRIEF.md
# Temperature-Hysteresis Fan Speed Controller

This block picks one of four fan speed levels from a stream of temperature samples and drives a fixed-period PWM signal for the fan driver. The level moves through a four-state machine. It steps up when the sample passes a rising threshold and steps down only when the sample falls below a lower, separate threshold. Each gap between the two thresholds forms a hysteresis band, so a temperature that hovers near one threshold cannot make the fan hunt between two speeds.

Samples arrive with a one-cycle valid strobe, once per control tick (nominally every 80 µs). The machine takes at most one step per strobe, even if the sample jumps past several thresholds. A configuration input gives one duty value per level. The PWM generator takes the duty of the current level at each period boundary, so every period holds a single duty. When the enable is low, the block parks at the lowest level with the fan output held low.

Top module: `fan_temp_ctrl`

## Requirements
- R1: After reset, `level_o` is 0 and `fan_pwm_o` is low.
- R2: `level_o` changes only on a clock edge at which both `temp_vld_i` and `en_i` are high. Otherwise it holds, apart from the forced return to 0 under R7.
- R3: Temperature is a signed 12-bit two's-complement value at 0.125 °C per LSB. Levels rise on strictly greater-than comparisons: 0 to 1 above 544 (68 °C), 1 to 2 above 584 (73 °C), and 2 to 3 above 624 (78 °C).
- R4: Levels fall on strictly less-than comparisons: 3 to 2 below 600 (75 °C), 2 to 1 below 560 (70 °C), and 1 to 0 below 520 (65 °C).
- R5: A sample that lies inside the current level's hysteresis band, equal to a threshold included, leaves the level unchanged.
- R6: A single strobe moves the level by at most one step, whatever the sample value, negative extremes included.
- R7: While `en_i` is low, the level is 0 from the next cycle on, `fan_pwm_o` is low, and strobes are ignored.
- R8: The PWM period is PERIOD clock cycles (default 64). In every steady period, the output is high for exactly as many cycles as the duty of the current level. The duty for level k sits in `level_duty_i[k*DUTY_W +: DUTY_W]`, with DUTY_W = 7 by default.
- R9: A duty of 0 holds the output low. A duty equal to or greater than PERIOD holds it high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| temp_i | input | 12 | Signed temperature sample, 0.125 °C/LSB |
| temp_vld_i | input | 1 | One-cycle strobe marking a new sample |
| level_duty_i | input | 4*DUTY_W | Duty per level, level k at bits k*DUTY_W upward |
| level_o | output | 2 | Current fan level, 0 to 3 |
| fan_pwm_o | output | 1 | Fixed-period fan PWM output |

## Verification
The assertions assume that `temp_i` and `level_duty_i` are stable while they are sampled, and that the duty table does not decrease from level 0 to level 3. They also assume that enable only gates the machine and is never treated as a reset. The stimulus changes inputs only on falling clock edges and pulses the strobe for a single cycle. It keeps the duty table monotonic, using one value of 0 and one above PERIOD so that both saturation cases are covered. The temperature sweeps run slowly up and down across every band, then jump to the extremes of the 12-bit range to show that each strobe takes only one step.

// File: rtl/fan_ctrl_pkg.sv
package fan_ctrl_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/fan_lvl_fsm.sv
module fan_lvl_fsm
  import fan_ctrl_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter logic signed [TEMP_W-1:0] RISE_0_1 = 12'sd544,
  parameter logic signed [TEMP_W-1:0] RISE_1_2 = 12'sd584,
  parameter logic signed [TEMP_W-1:0] RISE_2_3 = 12'sd624,
  parameter logic signed [TEMP_W-1:0] FALL_1_0 = 12'sd520,
  parameter logic signed [TEMP_W-1:0] FALL_2_1 = 12'sd560,
  parameter logic signed [TEMP_W-1:0] FALL_3_2 = 12'sd600
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     temp_vld_i,
  output lvl_t                     lvl_o
);
  localparam logic signed [TEMP_W-1:0] RISE_T [NUM_LVL-1] = '{RISE_0_1, RISE_1_2, RISE_2_3};
  localparam logic signed [TEMP_W-1:0] FALL_T [NUM_LVL-1] = '{FALL_1_0, FALL_2_1, FALL_3_2};

  logic [NUM_LVL-1:0] go_up, go_dn;
  lvl_t lvl_q, lvl_d;

  // go_up[k]: leave level k upward; go_dn[k]: leave level k downward
  assign go_up[NUM_LVL-1] = 1'b0;
  assign go_dn[0]         = 1'b0;
  for (genvar k = 0; k < NUM_LVL - 1; k++) begin : g_cmp
    assign go_up[k]   = temp_i > RISE_T[k];
    assign go_dn[k+1] = temp_i < FALL_T[k];
  end

  always_comb begin
    lvl_d = lvl_q;
    if (temp_vld_i) begin
      if (go_up[lvl_q])      lvl_d = lvl_q + lvl_t'(1);
      else if (go_dn[lvl_q]) lvl_d = lvl_q - lvl_t'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= '0;
    else if (!en_i) lvl_q <= '0;
    else            lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  // R2
  a_r2_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !temp_vld_i) |=> $stable(lvl_q));
  // R6
  a_r6_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> (lvl_q == $past(lvl_q)) ||
                    (int'(lvl_q) == int'($past(lvl_q)) + 1) ||
                    (int'(lvl_q) == int'($past(lvl_q)) - 1));
  // R3
  a_r3_rise_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && temp_vld_i && lvl_q == lvl_t'(0) && temp_i > RISE_0_1) |=> lvl_q == lvl_t'(1));
  // R4
  a_r4_fall_from_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && temp_vld_i && lvl_q == lvl_t'(NUM_LVL-1) && temp_i < FALL_3_2)
      |=> lvl_q == lvl_t'(NUM_LVL-2));
  // R7
  a_r7_park_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> lvl_q == '0);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int PERIOD = 64,
  localparam int CNT_W  = $clog2(PERIOD),
  localparam int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DUTY_W-1:0] duty_q;
  logic              pwm_q;
  logic              wrap;

  assign wrap = cnt_q == CNT_W'(PERIOD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      duty_q <= duty_i;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      if (wrap) duty_q <= duty_i;  // duty only changes at period boundary
      pwm_q <= DUTY_W'(cnt_q) < duty_q;
    end
  end

  assign pwm_o = pwm_q;

  // R7
  a_r7_pwm_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_q);
  // R9
  a_r9_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == '0) |=> !pwm_q);
  // R9
  a_r9_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && duty_q >= DUTY_W'(PERIOD)) |=> pwm_q);
endmodule

// File: rtl/fan_temp_ctrl.sv
module fan_temp_ctrl
  import fan_ctrl_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int PERIOD = 64,
  parameter logic signed [TEMP_W-1:0] RISE_0_1 = 12'sd544,
  parameter logic signed [TEMP_W-1:0] RISE_1_2 = 12'sd584,
  parameter logic signed [TEMP_W-1:0] RISE_2_3 = 12'sd624,
  parameter logic signed [TEMP_W-1:0] FALL_1_0 = 12'sd520,
  parameter logic signed [TEMP_W-1:0] FALL_2_1 = 12'sd560,
  parameter logic signed [TEMP_W-1:0] FALL_3_2 = 12'sd600,
  localparam int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic signed [TEMP_W-1:0]    temp_i,
  input  logic                        temp_vld_i,
  input  logic [NUM_LVL*DUTY_W-1:0]   level_duty_i,
  output logic [LVL_W-1:0]            level_o,
  output logic                        fan_pwm_o
);
  lvl_t              lvl;
  logic [DUTY_W-1:0] duty_sel;

  fan_lvl_fsm #(
    .TEMP_W(TEMP_W),
    .RISE_0_1(RISE_0_1), .RISE_1_2(RISE_1_2), .RISE_2_3(RISE_2_3),
    .FALL_1_0(FALL_1_0), .FALL_2_1(FALL_2_1), .FALL_3_2(FALL_3_2)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .temp_i     (temp_i),
    .temp_vld_i (temp_vld_i),
    .lvl_o      (lvl)
  );

  assign duty_sel = level_duty_i[lvl*DUTY_W +: DUTY_W];

  fan_pwm_gen #(.PERIOD(PERIOD)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .duty_i (duty_sel),
    .pwm_o  (fan_pwm_o)
  );

  assign level_o = lvl;
endmodule

// File: tb/fan_temp_ctrl_tb.sv
module fan_temp_ctrl_tb;
  localparam int PERIOD = 64;
  localparam int DUTY_W = $clog2(PERIOD + 1);
  localparam int WD     = 150000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic signed [11:0] temp_i = '0;
  logic temp_vld_i = 1'b0;
  logic [4*DUTY_W-1:0] level_duty_i;
  logic [1:0] level_o;
  logic fan_pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_lvl = 0;
  bit done = 0;
  int duty_tab [4] = '{0, 10, 37, 100};

  always #10 clk_i = ~clk_i;

  fan_temp_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .temp_i(temp_i),
    .temp_vld_i(temp_vld_i), .level_duty_i(level_duty_i),
    .level_o(level_o), .fan_pwm_o(fan_pwm_o)
  );

  function automatic int next_lvl(int s, int t);
    case (s)
      0: return (t > 544) ? 1 : 0;
      1: return (t > 584) ? 2 : ((t < 520) ? 0 : 1);
      2: return (t > 624) ? 3 : ((t < 560) ? 1 : 2);
      default: return (t < 600) ? 2 : 3;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(int t, string req);
    @(negedge clk_i);
    temp_i = 12'(t);
    temp_vld_i = 1'b1;
    @(negedge clk_i);
    temp_vld_i = 1'b0;
    if (en_i) exp_lvl = next_lvl(exp_lvl, t);
    chk(req, int'(level_o), exp_lvl);
  endtask

  task automatic high_count(output int n);
    n = 0;
    repeat (2 * PERIOD + 2) @(negedge clk_i);
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk_i);
      n += int'(fan_pwm_o);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int hc;
    for (int k = 0; k < 4; k++) level_duty_i[k*DUTY_W +: DUTY_W] = DUTY_W'(duty_tab[k]);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 level", int'(level_o), 0);
    chk("R1 pwm", int'(fan_pwm_o), 0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R1 level after release", int'(level_o), 0);

    // R8/R9 per level, climbing one level at a time
    high_count(hc);
    chk("R9 duty 0 level 0", hc, 0);
    strobe(700, "R3 climb to 1");
    high_count(hc);
    chk("R8 level 1 duty", hc, 10);
    strobe(700, "R3 climb to 2");
    high_count(hc);
    chk("R8 level 2 duty", hc, 37);
    strobe(700, "R3 climb to 3");
    high_count(hc);
    chk("R9 saturated duty level 3", hc, PERIOD);

    // R2: hot/cold sample without strobe leaves level
    @(negedge clk_i);
    temp_i = -12'sd2000;
    repeat (20) @(negedge clk_i);
    chk("R2 no strobe hold", int'(level_o), 3);

    // R6: extremes take a single step
    strobe(-2048, "R6 cold jump");
    strobe(-2048, "R6 cold jump");
    strobe(-2048, "R6 cold jump");
    strobe(2047, "R6 hot jump");
    strobe(2047, "R6 hot jump");
    strobe(-2048, "R6 cold jump");
    strobe(-2048, "R6 cold jump");
    chk("R6 reached 0", int'(level_o), 0);

    // R3/R4/R5: slow sweeps across every band
    for (int t = 500; t <= 660; t++) strobe(t, "R3 R5 up sweep");
    for (int t = 660; t >= 500; t--) strobe(t, "R4 R5 down sweep");
    for (int t = 500; t <= 590; t++) strobe(t, "R3 R5 partial up");
    for (int t = 590; t >= 555; t--) strobe(t, "R4 R5 partial down");
    // exact threshold values hold (R5)
    strobe(560, "R5 at fall threshold");
    strobe(584, "R5 at rise threshold");
    strobe(585, "R3 one above");
    strobe(624, "R5 at rise threshold 2");
    strobe(625, "R3 top");
    strobe(600, "R5 at fall threshold 3");
    strobe(599, "R4 one below");

    // R7: disable parks and ignores strobes
    @(negedge clk_i);
    en_i = 1'b0;
    exp_lvl = 0;
    @(negedge clk_i);
    chk("R7 parked", int'(level_o), 0);
    strobe(2047, "R7 strobe ignored");
    strobe(2047, "R7 strobe ignored");
    high_count(hc);
    chk("R7 pwm low when off", hc, 0);
    en_i = 1'b1;
    strobe(545, "R3 after re-enable");
    chk("R3 after re-enable level", int'(level_o), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule